// File: doc/BRIEF.md
# Grouped Four-Level Interrupt Priority Controller

This block sits between a small microcontroller core and its interrupt sources. Eleven sources feed it. Ten of them are single-cycle event pulses. The eleventh is a combined source built from two sub-events, and each sub-event has its own flag and its own enable. Each source latches a flag and is gated by its own enable and by a global enable. The sources are arranged in six groups. Each group takes one of four priority levels, formed from one bit in each of two priority registers.

Each cycle the controller picks the best pending request that may preempt the routine now running. It registers that request as a vector index and holds it until the core acknowledges it. On acknowledge the controller clears the flag of the winning source, unless that source is the combined one. It also records the winner's level as active. A return pulse from the core retires the highest active level. Software writes the enable, priority and flag registers through a simple write port and reads them back through an address-selected read port.

Top module: `irqp_ctrl`

## Requirements
- R1: After reset every register reads zero (addresses 0 to 5) and `irq_req` is low.
- R2: A pulse on `src_evt[i]` sets flag i, which reads back at address 3 bit i. Writing 1 to that bit at address 3 clears the flag. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R3: A source is pending only when three bits are all set: its flag, its enable (address 0 bit i), and the global enable (address 0 bit 15).
- R4: Sources 0 to 4 belong to groups 0 to 4, slot 0. Sources 5 to 9 belong to groups 0 to 4, slot 1. Source 10 alone forms group 5. The level of group g is {address 2 bit g, address 1 bit g}, and 3 is the highest level.
- R5: The winner is the eligible source with the highest level. A tie goes to the lower group number, and within a group slot 0 beats slot 1.
- R6: `irq_req` and `irq_vec` are registered. They appear on the clock edge after the pending state they reflect. Once raised, they stay unchanged until `irq_ack` is asserted, even if a better request arrives.
- R7: An acknowledge clears the flag of the source given by `irq_vec` for sources 0 to 9. It leaves the flag of source 10 unchanged.
- R8: `sub_evt[j]` sets sub-flag j, which reads at address 5 bit j and is cleared by writing 1 there. Address 4 bit j enables sub-flag j. While any enabled sub-flag is set, flag 10 is set. Only software writes clear flag 10 and the sub-flags.
- R9: A request is raised only if its level is strictly above the highest active level, or if no level is active. An acknowledge marks the acknowledged level active. `irq_ret` retires the highest active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 3 | Write address |
| cfg_wdata | input | 16 | Write data |
| cfg_raddr | input | 3 | Read address |
| cfg_rdata | output | 16 | Read data (combinational) |
| src_evt | input | 10 | Event pulses for sources 0 to 9 |
| sub_evt | input | 2 | Event pulses for the two sub-sources of source 10 |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 4 | Index of the requesting source |
| irq_ack | input | 1 | Core acknowledge of the held request |
| irq_ret | input | 1 | Core return from the current service routine |

## Verification
The assertions assume that the core pulses `irq_ack` only while `irq_req` is high, and that it pulses `irq_ret` only while some level is active and never in the same cycle as an acknowledge. The bench keeps to these rules. Every acknowledge follows an observed request. Each trial issues exactly as many returns as it made acknowledges, and it issues them in separate cycles. The bench also raises a sub-event one cycle ahead of the direct events. Because of this, all the flags of one trial become pending on the same edge, and the predicted winner is the winner over the whole event set.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  localparam int NPAIR = 5;
  localparam int NGRP  = NPAIR + 1;
  localparam int NSRC  = 2 * NPAIR + 1;
  localparam int CMB   = NSRC - 1;
  localparam int NSUB  = 2;
  localparam int NLVL  = 4;
  localparam int LVLW  = $clog2(NLVL);
  localparam int VECW  = $clog2(NSRC);
  localparam int REGW  = 16;
  localparam int ADRW  = 3;

  localparam logic [ADRW-1:0] A_EN     = 3'd0;
  localparam logic [ADRW-1:0] A_IPLO   = 3'd1;
  localparam logic [ADRW-1:0] A_IPHI   = 3'd2;
  localparam logic [ADRW-1:0] A_FLAG   = 3'd3;
  localparam logic [ADRW-1:0] A_SUBEN  = 3'd4;
  localparam logic [ADRW-1:0] A_SUBFLG = 3'd5;

  typedef logic [LVLW-1:0] lvl_t;
  typedef logic [VECW-1:0] vec_t;

  function automatic int unsigned grp_of(int unsigned s);
    if (s < NPAIR) return s;
    else if (s < 2 * NPAIR) return s - NPAIR;
    return NPAIR;
  endfunction

  // Polling rank r (0 = first polled) to source index.
  function automatic int unsigned src_at_rank(int unsigned r);
    if (r >= 2 * NPAIR) return CMB;
    return (r % 2 == 0) ? (r / 2) : (NPAIR + r / 2);
  endfunction

  function automatic lvl_t level_of(int unsigned s, logic [NGRP-1:0] lo, logic [NGRP-1:0] hi);
    int unsigned g;
    g = grp_of(s);
    return {hi[g], lo[g]};
  endfunction

  function automatic logic [NLVL-1:0] top_bit(logic [NLVL-1:0] a);
    logic [NLVL-1:0] r;
    r = '0;
    for (int i = 0; i < NLVL; i++) if (a[i]) r = NLVL'(1) << i;
    return r;
  endfunction

  function automatic lvl_t top_index(logic [NLVL-1:0] a);
    lvl_t r;
    r = '0;
    for (int i = 0; i < NLVL; i++) if (a[i]) r = lvl_t'(i);
    return r;
  endfunction
endpackage

// File: rtl/irqp_regs.sv
module irqp_regs
  import irqp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADRW-1:0]   wr_addr,
  input  logic [REGW-1:0]   wr_data,
  input  logic [ADRW-1:0]   rd_addr,
  output logic [REGW-1:0]   rd_data,
  input  logic [NSRC-2:0]   src_evt,
  input  logic [NSUB-1:0]   sub_evt,
  input  logic              ack_fire,
  input  vec_t              ack_vec,
  output logic [NSRC-1:0]   flags,
  output logic [NSRC-1:0]   src_en,
  output logic              glob_en,
  output logic [NGRP-1:0]   ip_lo,
  output logic [NGRP-1:0]   ip_hi
);
  localparam vec_t CMB_V = vec_t'(CMB);

  logic [NSUB-1:0] sub_en, sub_flag, sub_clr;
  logic [NSRC-1:0] flag_set, flag_clr, ack_clr;
  logic            wr_flag, ack_evt, cmb_raise;

  assign wr_flag   = wr_en && (wr_addr == A_FLAG);
  assign sub_clr   = (wr_en && wr_addr == A_SUBFLG) ? wr_data[NSUB-1:0] : '0;
  assign cmb_raise = |(sub_flag & sub_en);
  assign flag_set  = {cmb_raise, src_evt};
  assign ack_evt   = (ack_vec < CMB_V) ? src_evt[ack_vec] : 1'b0;

  always_comb begin
    ack_clr = '0;
    for (int s = 0; s < CMB; s++) ack_clr[s] = ack_fire && (ack_vec == vec_t'(s));
    flag_clr = ack_clr | (wr_flag ? wr_data[NSRC-1:0] : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_en <= '0; glob_en <= 1'b0; ip_lo <= '0; ip_hi <= '0;
      sub_en <= '0; sub_flag <= '0; flags <= '0;
    end else begin
      if (wr_en && wr_addr == A_EN) begin
        src_en  <= wr_data[NSRC-1:0];
        glob_en <= wr_data[REGW-1];
      end
      if (wr_en && wr_addr == A_IPLO)  ip_lo  <= wr_data[NGRP-1:0];
      if (wr_en && wr_addr == A_IPHI)  ip_hi  <= wr_data[NGRP-1:0];
      if (wr_en && wr_addr == A_SUBEN) sub_en <= wr_data[NSUB-1:0];
      sub_flag <= (sub_flag & ~sub_clr) | sub_evt;
      flags    <= (flags & ~flag_clr) | flag_set;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_EN:     begin rd_data[NSRC-1:0] = src_en; rd_data[REGW-1] = glob_en; end
      A_IPLO:   rd_data[NGRP-1:0] = ip_lo;
      A_IPHI:   rd_data[NGRP-1:0] = ip_hi;
      A_FLAG:   rd_data[NSRC-1:0] = flags;
      A_SUBEN:  rd_data[NSUB-1:0] = sub_en;
      A_SUBFLG: rd_data[NSUB-1:0] = sub_flag;
      default:  rd_data = '0;
    endcase
  end

  // R7: acknowledging a direct source drops its flag unless a new event lands
  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && ack_vec != CMB_V && !ack_evt) |=> !flags[$past(ack_vec)]);
  // R8: the combined flag survives everything but a software clear
  p_cmb_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[CMB] && !(wr_flag && wr_data[CMB])) |=> flags[CMB]);
  // R8: sub-flags survive acknowledges
  p_sub_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_flag[0] && sub_clr[0] == 1'b0) |=> sub_flag[0]);
endmodule

// File: rtl/irqp_arb.sv
module irqp_arb
  import irqp_pkg::*;
(
  input  logic [NSRC-1:0] elig,
  input  logic [NGRP-1:0] ip_lo,
  input  logic [NGRP-1:0] ip_hi,
  output logic            win_valid,
  output vec_t            win_vec,
  output lvl_t            win_lvl
);
  always_comb begin
    int unsigned s;
    lvl_t l;
    win_valid = 1'b0;
    win_vec   = '0;
    win_lvl   = '0;
    // Scan from the last-polled rank back to the first; ">=" lets earlier ranks win ties.
    for (int r = NSRC - 1; r >= 0; r--) begin
      s = src_at_rank(int'(r));
      l = level_of(s, ip_lo, ip_hi);
      if (elig[s] && (!win_valid || l >= win_lvl)) begin
        win_valid = 1'b1;
        win_vec   = vec_t'(s);
        win_lvl   = l;
      end
    end
  end
endmodule

// File: rtl/irqp_nest.sv
module irqp_nest
  import irqp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  lvl_t            push_lvl,
  input  logic            pop,
  output logic            any_act,
  output lvl_t            cur_lvl
);
  logic [NLVL-1:0] act, act_nx;

  always_comb begin
    act_nx = pop ? (act & ~top_bit(act)) : act;
    if (push) act_nx = act_nx | (NLVL'(1) << push_lvl);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) act <= '0;
    else        act <= act_nx;
  end

  assign any_act = |act;
  assign cur_lvl = top_index(act);

  // R9: a level can only be entered above everything already active
  p_push_above_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!any_act || push_lvl > cur_lvl));
  // R9: a lone return retires exactly one level
  p_pop_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && any_act) |=> ($countones(act) + 1 == $countones($past(act))));
endmodule

// File: rtl/irqp_ctrl.sv
module irqp_ctrl
  import irqp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_waddr,
  input  logic [15:0]     cfg_wdata,
  input  logic [2:0]      cfg_raddr,
  output logic [15:0]     cfg_rdata,
  input  logic [9:0]      src_evt,
  input  logic [1:0]      sub_evt,
  output logic            irq_req,
  output logic [3:0]      irq_vec,
  input  logic            irq_ack,
  input  logic            irq_ret
);
  logic [NSRC-1:0] flags, src_en, pend, elig;
  logic [NGRP-1:0] ip_lo, ip_hi;
  logic            glob_en, ack_fire, win_valid, any_act;
  logic            req_q;
  vec_t            vec_q, win_vec;
  lvl_t            lvl_q, win_lvl, cur_lvl;

  assign ack_fire = irq_ack && req_q;

  irqp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_waddr), .wr_data(cfg_wdata),
    .rd_addr(cfg_raddr), .rd_data(cfg_rdata), .src_evt(src_evt), .sub_evt(sub_evt),
    .ack_fire(ack_fire), .ack_vec(vec_q), .flags(flags), .src_en(src_en),
    .glob_en(glob_en), .ip_lo(ip_lo), .ip_hi(ip_hi)
  );

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      pend[s] = flags[s] && src_en[s] && glob_en;
      elig[s] = pend[s] && (!any_act || level_of(s, ip_lo, ip_hi) > cur_lvl);
    end
  end

  irqp_arb u_arb (
    .elig(elig), .ip_lo(ip_lo), .ip_hi(ip_hi),
    .win_valid(win_valid), .win_vec(win_vec), .win_lvl(win_lvl)
  );

  irqp_nest u_nest (
    .clk(clk), .rst_n(rst_n), .push(ack_fire), .push_lvl(lvl_q), .pop(irq_ret),
    .any_act(any_act), .cur_lvl(cur_lvl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0; vec_q <= '0; lvl_q <= '0;
    end else if (!req_q) begin
      req_q <= win_valid; vec_q <= win_vec; lvl_q <= win_lvl;
    end else if (irq_ack) begin
      req_q <= 1'b0;
    end
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;

  // R6: the presented request does not move until it is acknowledged
  p_vec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !irq_ack) |=> (req_q && $stable(vec_q) && $stable(lvl_q)));
  // R3: no request is raised while the global enable was off
  p_gen_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(glob_en));
  // R3: a freshly raised vector was pending in the arbitration cycle
  p_win_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> |($past(pend) & (NSRC'(1) << vec_q)));
  // R9: an acknowledge drops the request for at least one cycle
  p_ack_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !req_q);
endmodule

// File: tb/sim_irqp_ctrl.sv
`timescale 1ns/1ps
module sim_irqp_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_waddr = '0, cfg_raddr = '0;
  logic [15:0] cfg_wdata = '0, cfg_rdata;
  logic [9:0]  src_evt = '0;
  logic [1:0]  sub_evt = '0;
  logic        irq_req, irq_ack = 1'b0, irq_ret = 1'b0;
  logic [3:0]  irq_vec;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irqp_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .src_evt(src_evt), .sub_evt(sub_evt),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ret(irq_ret)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    cfg_raddr = a;
    #0.1;
    v = int'(cfg_rdata);
  endtask

  task automatic pulse(input logic [9:0] e);
    src_evt = e; step(1); src_evt = '0;
  endtask

  // Acknowledge with all flags cleared in the same cycle, then one return.
  task automatic ack_clear_ret();
    irq_ack = 1'b1; cfg_we = 1'b1; cfg_waddr = 3'd3; cfg_wdata = 16'h07FF;
    step(1);
    irq_ack = 1'b0; cfg_we = 1'b0; irq_ret = 1'b1;
    step(1);
    irq_ret = 1'b0;
    step(1);
  endtask

  task automatic ret_once();
    irq_ret = 1'b1; step(1); irq_ret = 1'b0;
  endtask

  // Reference: score = level*64 + (63 - polling position); the maximum score wins.
  function automatic int ref_win(input logic [10:0] m, input logic [5:0] lo, input logic [5:0] hi);
    int best, bs, g, slot, sc;
    best = -1; bs = -1;
    for (int s = 0; s < 11; s++) begin
      if (!m[s]) continue;
      g    = (s < 5) ? s : ((s < 10) ? s - 5 : 5);
      slot = (s >= 5 && s < 10) ? 1 : 0;
      sc   = (2 * int'(hi[g]) + int'(lo[g])) * 64 + (63 - (2 * g + slot));
      if (sc > best) begin best = sc; bs = s; end
    end
    return bs;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1: reset state
    chk("R1 irq_req", int'(irq_req), 0);
    for (int a = 0; a < 6; a++) begin rd(3'(a), v); chk("R1 register", v, 0); end

    // R3 global enable off; R2 flag latch and clear
    wr(3'd0, 16'h07FF);
    pulse(10'h008); step(2);
    chk("R3 no req with global off", int'(irq_req), 0);
    rd(3'd3, v); chk("R2 flag latched", v, 32'h008);
    wr(3'd3, 16'h0008);
    rd(3'd3, v); chk("R2 flag cleared", v, 0);

    // R3 per-source enable: source 2 disabled, source 7 wins
    wr(3'd0, 16'h87FB);
    pulse(10'h084); step(1);
    chk("R3 req", int'(irq_req), 1);
    chk("R3 winner skips disabled", int'(irq_vec), 7);
    ack_clear_ret();
    chk("R3 idle", int'(irq_req), 0);
    wr(3'd0, 16'h87FF);

    // R7 ack clears only the winner; R9 equal level does not preempt
    pulse(10'h012); step(1);
    chk("R5 group order", int'(irq_vec), 1);
    irq_ack = 1'b1; step(1); irq_ack = 1'b0;
    rd(3'd3, v); chk("R7 only winner cleared", v, 32'h010);
    step(1);
    chk("R9 equal level blocked", int'(irq_req), 0);
    ret_once(); step(1);
    chk("R9 after return", int'(irq_req), 1);
    chk("R9 after return vec", int'(irq_vec), 4);
    ack_clear_ret();

    // R8 combined source
    wr(3'd4, 16'h0001);
    sub_evt = 2'b10; step(1); sub_evt = '0; step(2);
    rd(3'd5, v); chk("R8 sub flag set", v, 2);
    rd(3'd3, v); chk("R8 disabled sub no flag10", v, 0);
    chk("R8 no req", int'(irq_req), 0);
    wr(3'd5, 16'h0002);
    rd(3'd5, v); chk("R8 sub flag w1c", v, 0);
    wr(3'd4, 16'h0003);
    sub_evt = 2'b01; step(1); sub_evt = '0; step(2);
    chk("R8 req", int'(irq_req), 1);
    chk("R8 vec", int'(irq_vec), 10);
    irq_ack = 1'b1; step(1); irq_ack = 1'b0;
    rd(3'd3, v); chk("R7 flag10 kept on ack", v, 32'h400);
    rd(3'd5, v); chk("R8 sub flag kept on ack", v, 1);
    ret_once(); step(1);
    chk("R8 sticky re-request", int'(irq_vec), 10);
    chk("R8 sticky req", int'(irq_req), 1);
    wr(3'd5, 16'h0003);
    ack_clear_ret();
    rd(3'd3, v); chk("R8 flags cleared by software", v, 0);
    chk("R8 idle", int'(irq_req), 0);

    // R9 nesting: group0 level1, group3 level2, group1 level0
    wr(3'd1, 16'h0001); wr(3'd2, 16'h0008);
    pulse(10'h001); step(1);
    chk("R9 first vec", int'(irq_vec), 0);
    irq_ack = 1'b1; step(1); irq_ack = 1'b0;
    pulse(10'h002); step(1);
    chk("R9 lower blocked", int'(irq_req), 0);
    pulse(10'h008); step(1);
    chk("R9 higher preempts", int'(irq_vec), 3);
    chk("R9 higher req", int'(irq_req), 1);
    irq_ack = 1'b1; step(1); irq_ack = 1'b0;
    step(1);
    chk("R9 two active", int'(irq_req), 0);
    ret_once(); step(1);
    chk("R9 one level still active", int'(irq_req), 0);
    ret_once(); step(1);
    chk("R9 unblocked", int'(irq_vec), 1);
    ack_clear_ret();

    // R6 hold: source 9 latched, then a level-3 request arrives
    wr(3'd1, 16'h0000); wr(3'd2, 16'h0000);
    pulse(10'h200); step(1);
    chk("R6 first", int'(irq_vec), 9);
    wr(3'd1, 16'h0001); wr(3'd2, 16'h0001);
    pulse(10'h001); step(2);
    chk("R6 vec held", int'(irq_vec), 9);
    chk("R6 req held", int'(irq_req), 1);
    irq_ack = 1'b1; step(1); irq_ack = 1'b0; step(1);
    chk("R9 level3 preempts level0", int'(irq_vec), 0);
    irq_ack = 1'b1; cfg_we = 1'b1; cfg_waddr = 3'd3; cfg_wdata = 16'h07FF;
    step(1);
    irq_ack = 1'b0; cfg_we = 1'b0;
    ret_once(); ret_once(); step(1);
    chk("R9 all retired", int'(irq_req), 0);

    // R4/R5 sweep over priority settings and event sets
    wr(3'd4, 16'h0001);
    for (int p = 0; p < 16; p++) begin
      logic [5:0] lo, hi;
      lo = 6'((p * 13 + 3) & 63);
      hi = 6'((p * 7 + 5) & 63);
      wr(3'd1, {10'd0, lo}); wr(3'd2, {10'd0, hi});
      for (int m = 0; m < 8; m++) begin
        logic [10:0] msk;
        int exp;
        msk = 11'(((m + 1) * 32'h2A7 + p * 32'h91) & 32'h7FF);
        if (msk == 0) msk = 11'h001;
        exp = ref_win(msk, lo, hi);
        sub_evt = msk[10] ? 2'b01 : 2'b00; step(1); sub_evt = '0;
        pulse(msk[9:0]); step(1);
        chk("R5 sweep req", int'(irq_req), 1);
        chk("R4 R5 sweep winner", int'(irq_vec), exp);
        wr(3'd5, 16'h0003);
        ack_clear_ret();
        chk("R6 sweep idle", int'(irq_req), 0);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule